// File: doc/BRIEF.md
# Masked CAM Search Engine

This block looks up a 64-bit key in a small content-addressable table while ignoring any bit positions selected by a global don't-care mask. Software places the key in four 16-bit I/O registers and pulses a command strobe. The engine then reads the table one entry per clock through a read port, in address order. It compares every valid entry against the key, using only the bit positions where the mask holds 0.

The search always takes the same number of cycles, whatever the result. At the end the engine updates a last-match flag. On a hit it writes the whole stored entry back into the four I/O registers through a write strobe. If the completion interrupt is enabled, it raises that interrupt whether or not the search hit. While a search runs, the engine reports busy and drops any further command strobes. The caller must not load duplicate entries; if two entries match, the engine reports the lowest-addressed one.

Top module: `camSearch`

## Requirements
- R1: The search key is `{ioIn3, ioIn2, ioIn1, ioIn0}`, so bit 15 of `ioIn3` is key bit 63 and bit 0 of `ioIn0` is key bit 0.
- R2: A mask bit of 1 removes that key position from the comparison, and a mask bit of 0 makes the position take part.
- R3: On a hit, `matchFlag` becomes 1 and `ioWrEn` pulses for one cycle together with `done`. `{ioOut3, ioOut2, ioOut1, ioOut0}` then carries the full stored entry, including the bits under the mask.
- R4: On a miss, `matchFlag` becomes 0, `ioWrEn` stays low and the `ioOut` values keep their previous contents.
- R5: An entry whose `tblValid` is 0 never matches, whatever its data.
- R6: `busy` is high for exactly 16 cycles after the clock edge that accepts `cmdStart`. `done` pulses for one cycle, in the cycle right after `busy` falls, 16 cycles after the accepting edge.
- R7: `irq` pulses with `done` exactly when `irqEn[2]` is 1 at completion, on a hit or a miss alike. The other `irqEn` bits have no effect.
- R8: A `cmdStart` seen while `busy` is high is ignored: it neither restarts nor extends the running search.
- R9: During a search, `tblAddr` steps through 0, 1, …, 15, one address per busy cycle.
- R10: After reset, `busy`, `done`, `irq`, `ioWrEn` and `matchFlag` are 0 and the `ioOut` values are 0.
- R11: The key and the mask are captured at the accepting edge. Changes to `ioIn*` or `maskIn` during a search do not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Start-search strobe |
| ioIn0 | input | 16 | I/O register 0 (key bits 15:0) |
| ioIn1 | input | 16 | I/O register 1 (key bits 31:16) |
| ioIn2 | input | 16 | I/O register 2 (key bits 47:32) |
| ioIn3 | input | 16 | I/O register 3 (key bits 63:48) |
| maskIn | input | 64 | Global mask, 1 = ignore bit |
| irqEn | input | 8 | Interrupt enables, bit 2 = search complete |
| tblAddr | output | 4 | Table read address |
| tblData | input | 64 | Entry data at `tblAddr` (same cycle) |
| tblValid | input | 1 | Valid bit of the entry at `tblAddr` |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Completion interrupt pulse |
| matchFlag | output | 1 | Result of the last search |
| ioWrEn | output | 1 | Write-back strobe for the I/O registers |
| ioOut0 | output | 16 | Write-back value, register 0 |
| ioOut1 | output | 16 | Write-back value, register 1 |
| ioOut2 | output | 16 | Write-back value, register 2 |
| ioOut3 | output | 16 | Write-back value, register 3 |

## Verification
The bench places hits at address 0 and at address 15. A scan that is off by one cycle, or that stops early, misses one of these and reports the wrong flag. Keys that set only bit 63 or only bit 0 catch a reversed register concatenation. A masked hit whose stored data differs from the key under the mask shows whether the write-back returns the stored entry or echoes the key. An invalid entry holding the key's exact value, and a strobe fired mid-search, would show up as a false hit or a shifted `done`. Changing the key and mask during a search exposes an engine that compares against the live inputs.

// File: rtl/camSearchPkg.sv
package camSearchPkg;
  typedef struct packed {
    logic load;    // accept new command, capture key and mask
    logic scan;    // compare the entry currently addressed
    logic finish;  // last compare, publish result
  } ctrlStrobeT;
endpackage

// File: rtl/camSearchCtrl.sv
module camSearchCtrl
  import camSearchPkg::*;
#(
  parameter int DEPTH = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  output logic              busy,
  output logic [ADDR_W-1:0] idx,
  output ctrlStrobeT        strobes
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (!busy && cmdStart) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      if (idx == LAST) busy <= 1'b0;
      idx <= idx + 1'b1;
    end
  end

  always_comb begin
    strobes.load   = !busy && cmdStart;
    strobes.scan   = busy;
    strobes.finish = busy && (idx == LAST);
  end
endmodule

// File: rtl/camSearchDp.sv
module camSearchDp
  import camSearchPkg::*;
#(
  parameter int KEY_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobes,
  input  logic [KEY_W-1:0] keyIn,
  input  logic [KEY_W-1:0] maskIn,
  input  logic [KEY_W-1:0] tblData,
  input  logic             tblValid,
  input  logic             irqEnBit,
  output logic             matchFlag,
  output logic [KEY_W-1:0] ioWrData,
  output logic             ioWrEn,
  output logic             done,
  output logic             irq
);
  logic [KEY_W-1:0] keyQ, maskQ, hitData;
  logic             hitSeen, matchNow, hitAny;
  logic [KEY_W-1:0] resultData;

  always_comb begin
    matchNow   = strobes.scan && tblValid && (((tblData ^ keyQ) & ~maskQ) == '0);
    hitAny     = hitSeen || matchNow;
    resultData = hitSeen ? hitData : tblData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyQ      <= '0;
      maskQ     <= '0;
      hitData   <= '0;
      hitSeen   <= 1'b0;
      matchFlag <= 1'b0;
      ioWrData  <= '0;
      ioWrEn    <= 1'b0;
      done      <= 1'b0;
      irq       <= 1'b0;
    end else begin
      done   <= strobes.finish;
      irq    <= strobes.finish && irqEnBit;
      ioWrEn <= 1'b0;
      if (strobes.load) begin
        keyQ    <= keyIn;
        maskQ   <= maskIn;
        hitSeen <= 1'b0;
      end
      if (matchNow && !hitSeen) begin
        hitSeen <= 1'b1;
        hitData <= tblData;
      end
      if (strobes.finish) begin
        matchFlag <= hitAny;
        if (hitAny) begin
          ioWrData <= resultData;
          ioWrEn   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/camSearch.sv
module camSearch
  import camSearchPkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int REG_W   = 16,
  parameter int IRQ_W   = 8,
  parameter int IRQ_BIT = 2,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int KEY_W  = 4 * REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic [REG_W-1:0]  ioIn0,
  input  logic [REG_W-1:0]  ioIn1,
  input  logic [REG_W-1:0]  ioIn2,
  input  logic [REG_W-1:0]  ioIn3,
  input  logic [KEY_W-1:0]  maskIn,
  input  logic [IRQ_W-1:0]  irqEn,
  output logic [ADDR_W-1:0] tblAddr,
  input  logic [KEY_W-1:0]  tblData,
  input  logic              tblValid,
  output logic              busy,
  output logic              done,
  output logic              irq,
  output logic              matchFlag,
  output logic              ioWrEn,
  output logic [REG_W-1:0]  ioOut0,
  output logic [REG_W-1:0]  ioOut1,
  output logic [REG_W-1:0]  ioOut2,
  output logic [REG_W-1:0]  ioOut3
);
  ctrlStrobeT       strobes;
  logic [KEY_W-1:0] keyWord, wrWord;

  assign keyWord = {ioIn3, ioIn2, ioIn1, ioIn0};
  assign {ioOut3, ioOut2, ioOut1, ioOut0} = wrWord;

  camSearchCtrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart),
    .busy(busy), .idx(tblAddr), .strobes(strobes)
  );

  camSearchDp #(.KEY_W(KEY_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .keyIn(keyWord), .maskIn(maskIn),
    .tblData(tblData), .tblValid(tblValid), .irqEnBit(irqEn[IRQ_BIT]),
    .matchFlag(matchFlag), .ioWrData(wrWord), .ioWrEn(ioWrEn),
    .done(done), .irq(irq)
  );
endmodule

// File: rtl/camSearchChk.sv
module camSearchChk #(
  parameter int DEPTH = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              irq,
  input logic              matchFlag,
  input logic              ioWrEn,
  input logic [ADDR_W-1:0] tblAddr
);
  logic [31:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1;
    else           busyCnt <= '0;
  end

  AST_DONE_AFTER_FULL_SCAN: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyCnt == DEPTH)); // R6
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R6
  AST_IRQ_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> done); // R7
  AST_WRITEBACK_ON_HIT: assert property (@(posedge clk) disable iff (!rstN)
    ioWrEn |-> (done && matchFlag)); // R3
  AST_NO_WRITE_ON_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (done && !matchFlag) |-> !ioWrEn); // R4
  AST_ADDR_STEPS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (tblAddr == ADDR_W'($past(tblAddr) + 1'b1))); // R9
endmodule

bind camSearch camSearchChk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .irq(irq),
  .matchFlag(matchFlag), .ioWrEn(ioWrEn), .tblAddr(tblAddr)
);

// File: tb/camSearch_tb_top.sv
module camSearch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdStart = 1'b0;
  logic [15:0] ioIn0 = '0, ioIn1 = '0, ioIn2 = '0, ioIn3 = '0;
  logic [63:0] maskIn = '0;
  logic [7:0]  irqEn = '0;
  logic [3:0]  tblAddr;
  logic [63:0] tblData;
  logic        tblValid;
  logic        busy, done, irq, matchFlag, ioWrEn;
  logic [15:0] ioOut0, ioOut1, ioOut2, ioOut3;

  logic [63:0] tblMem [DEPTH];
  logic        vldMem [DEPTH];
  assign tblData  = tblMem[tblAddr];
  assign tblValid = vldMem[tblAddr];

  camSearch dut_i (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart),
    .ioIn0(ioIn0), .ioIn1(ioIn1), .ioIn2(ioIn2), .ioIn3(ioIn3),
    .maskIn(maskIn), .irqEn(irqEn), .tblAddr(tblAddr),
    .tblData(tblData), .tblValid(tblValid),
    .busy(busy), .done(done), .irq(irq), .matchFlag(matchFlag),
    .ioWrEn(ioWrEn), .ioOut0(ioOut0), .ioOut1(ioOut1),
    .ioOut2(ioOut2), .ioOut3(ioOut3)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  // behavioural reference
  int          remain = 0;
  logic        expBusy = 0, expDone = 0, expIrq = 0, expMatch = 0, expWrEn = 0;
  logic [63:0] expOut = '0;
  logic        pendHit = 0;
  logic [63:0] pendData = '0;
  string       curTag = "R6";

  always @(posedge clk) begin
    if (!rstN) begin
      remain = 0; expBusy = 0; expDone = 0; expIrq = 0;
      expMatch = 0; expWrEn = 0; expOut = '0;
    end else begin
      expDone = 0; expIrq = 0; expWrEn = 0;
      if (remain > 0) begin
        remain--;
        if (remain == 0) begin
          expBusy  = 0;
          expDone  = 1;
          expIrq   = irqEn[2];
          expMatch = pendHit;
          if (pendHit) begin
            expWrEn = 1;
            expOut  = pendData;
          end
        end
      end else if (cmdStart) begin
        logic [63:0] k;
        k = {ioIn3, ioIn2, ioIn1, ioIn0};
        remain  = DEPTH;
        expBusy = 1;
        pendHit = 0;
        for (int i = 0; i < DEPTH; i++) begin
          if (!pendHit && vldMem[i] && (((tblMem[i] ^ k) & ~maskIn) == '0)) begin
            pendHit  = 1;
            pendData = tblMem[i];
          end
        end
      end
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rstN) begin
      check("R10 busy", busy, 0);
      check("R10 done", done, 0);
      check("R10 irq", irq, 0);
      check("R10 matchFlag", matchFlag, 0);
      check("R10 ioWrEn", ioWrEn, 0);
      check("R10 ioOut", {ioOut3, ioOut2, ioOut1, ioOut0}, 0);
    end else begin
      check({curTag, " R6 busy"}, busy, expBusy);
      check({curTag, " R6 done"}, done, expDone);
      check({curTag, " R7 irq"}, irq, expIrq);
      check({curTag, " matchFlag"}, matchFlag, expMatch);
      check({curTag, " R3 ioWrEn"}, ioWrEn, expWrEn);
      check({curTag, " R3 ioOut"}, {ioOut3, ioOut2, ioOut1, ioOut0}, expOut);
      if (expBusy) check("R9 tblAddr", tblAddr, 64'(DEPTH - remain));
    end
  end

  task automatic setKey(logic [63:0] k);
    {ioIn3, ioIn2, ioIn1, ioIn0} = k;
  endtask

  task automatic search(string tag, logic [63:0] k, logic [63:0] m, logic [7:0] ie);
    @(negedge clk);
    curTag = tag;
    setKey(k); maskIn = m; irqEn = ie; cmdStart = 1;
    @(negedge clk);
    cmdStart = 0;
    repeat (DEPTH + 2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      tblMem[i] = {16'hA000 + 16'(i), 16'h1234, 16'h5600 + 16'(i), 16'h00F0 + 16'(i)};
      vldMem[i] = 1'b1;
    end
    tblMem[7]  = 64'h8000_0000_0000_0000;  // R1 only MSB
    tblMem[8]  = 64'h0000_0000_0000_0001;  // R1 only LSB
    tblMem[9]  = 64'hDEAD_BEEF_CAFE_0009;  // R5 invalid copy target
    vldMem[9]  = 1'b0;
    tblMem[10] = 64'hFE55_543A_0000_3020;  // R2 masked target
    repeat (3) @(negedge clk);
    rstN = 1;

    search("R3 hit mid", tblMem[5], '0, 8'h04);
    search("R3 hit first", tblMem[0], '0, 8'h04);
    search("R3 hit last", tblMem[15], '0, 8'h00);
    search("R4 miss", 64'h1111_2222_3333_4444, '0, 8'h04);
    search("R7 miss irq off", 64'h1111_2222_3333_4444, '0, 8'hFB);
    search("R1 msb", 64'h8000_0000_0000_0000, '0, 8'h04);
    search("R1 lsb", 64'h0000_0000_0000_0001, '0, 8'h04);
    search("R5 invalid", 64'hDEAD_BEEF_CAFE_0009, '0, 8'h04);
    // R2: key differs from entry 10 only in masked positions
    search("R2 masked hit", 64'h3E55_543A_FFFF_0000, 64'hC000_0000_FFFF_FFFF, 8'h04);
    search("R2 unmasked diff", 64'h3E55_543B_0000_3020, 64'hC000_0000_FFFF_FFFF, 8'h04);

    // R8: strobe mid-search ignored; R11: inputs change mid-search
    @(negedge clk);
    curTag = "R8 R11";
    setKey(tblMem[12]); maskIn = '0; irqEn = 8'h04; cmdStart = 1;
    @(negedge clk);
    cmdStart = 0;
    repeat (5) @(negedge clk);
    setKey(tblMem[3]); maskIn = '1; cmdStart = 1;
    @(negedge clk);
    cmdStart = 0;
    repeat (DEPTH + 2) @(negedge clk);

    // back-to-back: start right at done cycle edge
    curTag = "R6 back-to-back";
    setKey(tblMem[2]); maskIn = '0; cmdStart = 1;
    @(negedge clk);
    cmdStart = 1; setKey(tblMem[4]);
    repeat (DEPTH) @(negedge clk);
    cmdStart = 0;
    repeat (DEPTH + 4) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog expired: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule